// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This block works out where a 16-bit processor fetches its next instruction. It looks at the current instruction and handles five cases: conditional branches, register jumps, returns, and the PC-relative and register-based subroutine calls. For any other instruction it advances the program counter by one. For the two call forms it also asks for register 7 to be written with the return address.

The unit takes the current PC, the instruction word, the three condition flags, the contents of the base register the instruction names, and the contents of register 7. The surrounding core reads the register file, keeps the flags up to date, and writes the link register. The outputs are registered: inputs presented before a rising clock edge appear on the outputs after that edge.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `next_pc` = 0, `link_we` = 0 and `link_val` = 0 after that edge.
- R2: An instruction whose top four bits are not 0000, 0100 or 1100 gives `next_pc` = `cur_pc`+1 and `link_we` = 0.
- R3: A conditional branch (top bits 0000) reads its mask from bits 11..9. Bit 11 selects N, bit 10 selects Z and bit 9 selects P. The `flags` input is ordered {N,Z,P}. When a selected flag is set, `next_pc` = `cur_pc`+1+sign-extended bits 8..0. Otherwise `next_pc` = `cur_pc`+1.
- R4: A branch mask of 000 never changes the flow, whatever the flags. A mask of 111 always takes the branch, even when all flags are 0.
- R5: A register jump (top bits 1100) sets `next_pc` to the register named in bits 8..6. That is `base_val`, or `r7_val` when the field is 7 (the return form). No link write is made.
- R6: A call with top bits 0100 and bit 11 = 1 sets `next_pc` = `cur_pc`+1+sign-extended bits 10..0. It also sets `link_we` = 1 and `link_val` = `cur_pc`+1.
- R7: A call with top bits 0100 and bit 11 = 0 sets `next_pc` to `base_val`. It also sets `link_we` = 1 and `link_val` = `cur_pc`+1.
- R8: A register call whose base field (bits 8..6) is 7 jumps to the `r7_val` input, not to the new link value.
- R9: All PC arithmetic wraps modulo 2^16. A relative offset of -1 gives `next_pc` = `cur_pc`.
- R10: `link_we` is 1 only after a 0100 instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 16 | Address of the current instruction |
| instr | input | 16 | Current instruction word |
| flags | input | 3 | Condition flags {N,Z,P} |
| base_val | input | 16 | Value of the register named in bits 8..6 |
| r7_val | input | 16 | Value of register 7 |
| next_pc | output | 16 | Registered next program counter |
| link_we | output | 1 | Registered register-7 write enable |
| link_val | output | 16 | Registered return address |

## Verification
The branch is tried with each single-bit mask against matching and non-matching flags, which separates the N, Z and P lanes. The all-zero and all-one masks are tried against every flag pattern, which shows whether the flag match is being bypassed. Offsets of -1, the largest positive value and the most negative value, with the PC near 0xFFFF, show that sign extension and wrap are correct. Calls and jumps through register 7 with `base_val` and `r7_val` set to different values show which source each form uses. A long run of random instructions, checked against the reference every clock, covers the non-control opcodes.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int W        = 16;
    localparam int OPC_W    = 4;
    localparam int IDX_W    = 3;
    localparam int BR_OFF_W = 9;
    localparam int JS_OFF_W = 11;
    localparam int LINK_IDX = 7;

    localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_CALL   = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 4'b1100;

    typedef enum logic [1:0] {
        K_SEQ,
        K_BRANCH,
        K_JUMP,
        K_CALL
    } kind_e;

    typedef enum logic {
        TGT_REL,
        TGT_REG
    } tsel_e;

    typedef struct packed {
        kind_e             kind;
        tsel_e             tsel;
        logic [IDX_W-1:0]  cond_mask;
        logic [IDX_W-1:0]  base_idx;
        logic [W-1:0]      offset;
    } dec_t;

    function automatic logic [W-1:0] sext_field(input logic [W-1:0] raw, input int nbits);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[i] = (i < nbits) ? raw[i] : raw[nbits-1];
        end
        return r;
    endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [W-1:0] instr,
    output dec_t         dec
);
    logic [OPC_W-1:0] opc;
    assign opc = instr[W-1 -: OPC_W];

    always_comb begin
        dec.kind      = K_SEQ;
        dec.tsel      = TGT_REL;
        dec.cond_mask = instr[11:9];
        dec.base_idx  = instr[8:6];
        dec.offset    = sext_field(instr, BR_OFF_W);
        unique case (opc)
            OPC_BRANCH: begin
                dec.kind = K_BRANCH;
            end
            OPC_JUMP: begin
                dec.kind = K_JUMP;
                dec.tsel = TGT_REG;
            end
            OPC_CALL: begin
                dec.kind   = K_CALL;
                dec.tsel   = instr[11] ? TGT_REL : TGT_REG;
                dec.offset = sext_field(instr, JS_OFF_W);
            end
            default: dec.kind = K_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  logic [IDX_W-1:0] mask,
    input  logic [IDX_W-1:0] flags,
    output logic             taken
);
    logic [IDX_W-1:0] hit;

    for (genvar g = 0; g < IDX_W; g++) begin : g_lane
        assign hit[g] = mask[g] & flags[g];
    end

    assign taken = (|hit) | (&mask);
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  dec_t         dec,
    input  logic         taken,
    input  logic [W-1:0] cur_pc,
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] r7_val,
    output logic [W-1:0] nxt,
    output logic         lnk_we,
    output logic [W-1:0] lnk_val
);
    logic [W-1:0] seq_pc;
    logic [W-1:0] rel_pc;
    logic [W-1:0] reg_pc;

    assign seq_pc = cur_pc + W'(1);
    assign rel_pc = seq_pc + dec.offset;
    assign reg_pc = (dec.base_idx == IDX_W'(LINK_IDX)) ? r7_val : base_val;

    always_comb begin
        nxt     = seq_pc;
        lnk_we  = 1'b0;
        lnk_val = seq_pc;
        case (dec.kind)
            K_BRANCH: nxt = taken ? rel_pc : seq_pc;
            K_JUMP:   nxt = reg_pc;
            K_CALL: begin
                nxt    = (dec.tsel == TGT_REL) ? rel_pc : reg_pc;
                lnk_we = 1'b1;
            end
            default:  nxt = seq_pc;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [15:0]  cur_pc,
    input  logic [15:0]  instr,
    input  logic [2:0]   flags,
    input  logic [15:0]  base_val,
    input  logic [15:0]  r7_val,
    output logic [15:0]  next_pc,
    output logic         link_we,
    output logic [15:0]  link_val
);
    dec_t         dec;
    logic         taken;
    logic [W-1:0] nxt_c;
    logic         we_c;
    logic [W-1:0] lv_c;

    npc_decode u_dec (.instr(instr), .dec(dec));
    npc_cond   u_cond (.mask(dec.cond_mask), .flags(flags), .taken(taken));
    npc_target u_tgt (
        .dec(dec), .taken(taken), .cur_pc(cur_pc), .base_val(base_val),
        .r7_val(r7_val), .nxt(nxt_c), .lnk_we(we_c), .lnk_val(lv_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc  <= '0;
            link_we  <= 1'b0;
            link_val <= '0;
        end else begin
            next_pc  <= nxt_c;
            link_we  <= we_c;
            link_val <= lv_c;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (next_pc == '0 && !link_we && link_val == '0));

    p_plain_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(instr[15:12] != 4'b0000 && instr[15:12] != 4'b0100
                              && instr[15:12] != 4'b1100))
        |-> (next_pc == $past(cur_pc) + 16'd1 && !link_we));

    p_never_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(instr[15:9] == 7'b0000_000))
        |-> (next_pc == $past(cur_pc) + 16'd1));

    p_ret_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(instr[15:12] == 4'b1100 && instr[8:6] == 3'd7))
        |-> (next_pc == $past(r7_val) && !link_we));

    p_link_r6: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_val == $past(cur_pc) + 16'd1));

    p_jsrr_old_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(instr[15:11] == 5'b01000 && instr[8:6] == 3'd7))
        |-> (next_pc == $past(r7_val)));

    p_link_only_call_r10: assert property (@(posedge clk) disable iff (rst)
        link_we |-> ($past(instr[15:12]) == 4'b0100));
endmodule

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cur_pc, instr, base_val, r7_val;
    logic [2:0]  flags;
    logic [15:0] next_pc, link_val;
    logic        link_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    npc_unit u0 (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .instr(instr), .flags(flags),
        .base_val(base_val), .r7_val(r7_val), .next_pc(next_pc),
        .link_we(link_we), .link_val(link_val)
    );

    function automatic logic [15:0] sx(input int v, input int bits);
        int o = v;
        if (o >= (1 << (bits - 1))) o -= (1 << bits);
        return 16'(o);
    endfunction

    task automatic check(input string tag, input logic [15:0] a_pc, input logic [15:0] e_pc,
                         input logic a_we, input logic e_we,
                         input logic [15:0] a_lv, input logic [15:0] e_lv);
        checks++;
        if (a_pc !== e_pc || a_we !== e_we || (e_we && a_lv !== e_lv)) begin
            fails++;
            $display("FAIL %s: pc=%h we=%b lv=%h expected pc=%h we=%b lv=%h",
                     tag, a_pc, a_we, a_lv, e_pc, e_we, e_lv);
        end
    endtask

    task automatic step(input string tag, input logic [15:0] pc, input logic [15:0] ins,
                        input logic [2:0] fl, input logic [15:0] bv, input logic [15:0] r7);
        logic [15:0] seq, e_pc;
        logic        e_we;
        int          op, m, idx;
        @(negedge clk);
        cur_pc = pc; instr = ins; flags = fl; base_val = bv; r7_val = r7;
        seq  = pc + 16'd1;
        e_pc = seq;
        e_we = 1'b0;
        op   = int'(ins[15:12]);
        idx  = int'(ins[8:6]);
        if (op == 0) begin
            m = int'(ins[11:9]);
            if (m == 7 || (m & int'(fl)) != 0) e_pc = seq + sx(int'(ins[8:0]), 9);
        end else if (op == 12) begin
            e_pc = (idx == 7) ? r7 : bv;
        end else if (op == 4) begin
            e_we = 1'b1;
            if (ins[11]) e_pc = seq + sx(int'(ins[10:0]), 11);
            else         e_pc = (idx == 7) ? r7 : bv;
        end
        @(posedge clk);
        #1;
        check(tag, next_pc, e_pc, link_we, e_we, link_val, seq);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cur_pc = 16'h1234; instr = 16'h4801; flags = 3'b111;
        base_val = 16'h5555; r7_val = 16'h7777;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", next_pc, 16'h0, link_we, 1'b0, link_val, 16'h0);
        @(negedge clk);
        rst = 1'b0;

        step("R2 plain add",   16'h3000, 16'h1021, 3'b000, 16'h0, 16'h0);
        step("R2 plain ld",    16'hFFFF, 16'h25FC, 3'b111, 16'h0, 16'h0);
        step("R2 plain rti",   16'h0100, 16'h8000, 3'b010, 16'h0, 16'h0);
        step("R3 N hit",       16'h3005, 16'h0803, 3'b100, 16'h0, 16'h0);
        step("R3 N miss",      16'h3005, 16'h0803, 3'b011, 16'h0, 16'h0);
        step("R3 Z hit",       16'h3005, 16'h0403, 3'b010, 16'h0, 16'h0);
        step("R3 Z miss",      16'h3005, 16'h0403, 3'b101, 16'h0, 16'h0);
        step("R3 P hit back",  16'h3005, 16'h03FD, 3'b001, 16'h0, 16'h0);
        step("R3 P miss",      16'h3005, 16'h03FD, 3'b110, 16'h0, 16'h0);
        for (int f = 0; f < 8; f++) begin
            step("R4 mask none", 16'h4000, 16'h0055, 3'(f), 16'h0, 16'h0);
            step("R4 mask all",  16'h4000, 16'h0E55, 3'(f), 16'h0, 16'h0);
        end
        step("R5 jmp",         16'h3008, 16'hC180, 3'b000, 16'h3123, 16'h9999);
        step("R5 ret",         16'h3013, 16'hC1C0, 3'b000, 16'h1111, 16'h3012);
        step("R6 jsr fwd",     16'h3011, 16'h4801, 3'b000, 16'h0, 16'h0);
        step("R6 jsr max",     16'h0010, 16'h4BFF, 3'b000, 16'h0, 16'h0);
        step("R6 jsr min",     16'h0010, 16'h4C00, 3'b000, 16'h0, 16'h0);
        step("R7 jsrr",        16'h2000, 16'h4080, 3'b000, 16'hABCD, 16'h1111);
        step("R8 jsrr r7",     16'h2000, 16'h41C0, 3'b000, 16'hABCD, 16'h1111);
        step("R9 br self",     16'h3012, 16'h0FFF, 3'b000, 16'h0, 16'h0);
        step("R9 br wrap",     16'hFFFE, 16'h0E05, 3'b000, 16'h0, 16'h0);
        step("R9 br max",      16'h0000, 16'h0EFF, 3'b000, 16'h0, 16'h0);
        step("R9 br min",      16'h0005, 16'h0F00, 3'b000, 16'h0, 16'h0);
        step("R9 jsr self",    16'h7FFF, 16'h4FFF, 3'b000, 16'h0, 16'h0);
        step("R10 after call", 16'h3000, 16'h5020, 3'b000, 16'h0, 16'h0);
        for (int i = 0; i < 400; i++) begin
            step("R10 random", 16'($urandom), 16'($urandom), 3'($urandom),
                 16'($urandom), 16'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule